// File: doc/BRIEF.md
# Cache Enable Sampling Qualifier

This block sits inside a processor bus interface and decides, for each bus cycle, whether the external cache-enable input is captured and what the captured value means. A bus cycle opens on the address strobe. The capture point is the first clock after that strobe in which either the first burst-ready or the next-address strobe appears, whichever comes first. Only that one clock per cycle is a candidate. If the cycle's type, the power state or the bus-control conditions forbid sampling in that clock, the cycle ends up noncacheable.

When a capture happens, the block raises a one-clock strobe in that same clock. It then latches a cacheable flag, which is the AND of the sampled cache-enable input and the processor's own cache-request output. It also latches a line policy, writeback or write-through, from the page-write-through output and the external writeback/write-through hint. Both results hold until the next address strobe or reset clears them. The cache array, line-fill sequencing and line-state storage are outside this block.

Top module: `cache_enable_qualifier`

## Requirements
- R1: While rst_n is low, and in the first clock after it, cap_stb, cacheable and wb_policy are all 0.
- R2: After a cyc_start, cap_stb is 1 in the first later clock where first_brdy or next_addr is 1, provided that clock qualifies. No later clock of the same bus cycle can raise cap_stb, whether or not the first one qualified.
- R3: Only the memory-read cycle kind (cyc_kind code 0) can capture. Memory write (1), I/O (2), inquire (3), locked (4), special (5) and interrupt acknowledge (6) never raise cap_stb. The kind is the one presented with cyc_start.
- R4: Capture needs power_st equal to 0 (running). Codes 1 shutdown, 2 halt, 3 stop-grant and 4 stop-clock block it. All four op_mode values (0 real, 1 protected, 2 virtual-8086, 3 system-management) allow it.
- R5: If backoff, hold_ack, hard_reset, init_req or probe_rdy is 1 in the sample clock, cap_stb stays 0 and cacheable stays 0 for that bus cycle.
- R6: With addr_hold 1 in the sample clock, capture is allowed only if addr_hold was 0 in the cyc_start clock of that bus cycle.
- R7: After a capture, cacheable equals cache_en AND cache_req as sampled in the capture clock. It is visible from the next clock and holds until the next cyc_start.
- R8: wb_policy is 1 exactly when the captured cacheable value is 1, pwt was 0 and wb_wt was 1 (1 = writeback) in the capture clock. Otherwise it is 0.
- R9: cyc_start clears cacheable and wb_policy from the next clock. A first_brdy or next_addr in the cyc_start clock itself is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| cyc_start | input | 1 | Address strobe; opens a new bus cycle |
| cyc_kind | input | 3 | Bus cycle kind, valid with cyc_start |
| op_mode | input | 2 | Operating mode indicator |
| power_st | input | 3 | Power/halt state indicator |
| backoff | input | 1 | Bus backoff asserted |
| hold_ack | input | 1 | Hold acknowledge asserted |
| hard_reset | input | 1 | Processor reset pin asserted |
| init_req | input | 1 | Processor init asserted |
| probe_rdy | input | 1 | Debug probe ready asserted |
| addr_hold | input | 1 | Address hold asserted |
| first_brdy | input | 1 | Burst-ready of the current cycle |
| next_addr | input | 1 | Next-address request |
| cache_en | input | 1 | External cache-enable input |
| cache_req | input | 1 | Processor cache-request output |
| pwt | input | 1 | Page write-through output |
| wb_wt | input | 1 | Writeback (1) / write-through (0) hint |
| cap_stb | output | 1 | One-clock capture strobe |
| cacheable | output | 1 | Latched cacheable decision |
| wb_policy | output | 1 | Latched line policy, 1 = writeback |

## Verification
Directed cycles separate the two orderings of the sample point, next-address before burst-ready and burst-ready alone. They show that the first strobe closes the window even when it is blocked. Each non-read kind, each stopping power state and each blocking bus signal is placed exactly on the sample clock, so that a gate tied to the wrong condition shows up as a missed or extra strobe. Address hold is applied once on a cycle that began before it and once on a cycle that began under it, which tells the two apart. The cache_en/cache_req/pwt/wb_wt combinations and a long seeded random run then cover overlap of all these inputs against a bench model.

// File: rtl/ceq_pkg.sv
package ceq_pkg;
  localparam int KIND_W = 3;
  localparam int PWR_W  = 3;
  localparam int MODE_W = 2;
  localparam int NUM_BLOCKERS = 5;

  typedef enum logic [KIND_W-1:0] {
    CK_MEM_RD  = 3'd0,
    CK_MEM_WR  = 3'd1,
    CK_IO      = 3'd2,
    CK_INQUIRE = 3'd3,
    CK_LOCKED  = 3'd4,
    CK_SPECIAL = 3'd5,
    CK_INTA    = 3'd6,
    CK_NONE    = 3'd7
  } cyc_kind_e;

  typedef enum logic [PWR_W-1:0] {
    PWR_RUN      = 3'd0,
    PWR_SHUTDOWN = 3'd1,
    PWR_HALT     = 3'd2,
    PWR_STOPGNT  = 3'd3,
    PWR_STOPCLK  = 3'd4
  } power_e;

  // Only memory reads may sample the cache-enable input.
  function automatic logic kind_allows(input logic [KIND_W-1:0] kind);
    return kind == CK_MEM_RD;
  endfunction

  // Any stopping state forbids sampling.
  function automatic logic power_allows(input logic [PWR_W-1:0] pst);
    return pst == PWR_RUN;
  endfunction

  // Real, protected, virtual-8086 and system-management modes all sample.
  function automatic logic mode_allows(input logic [MODE_W-1:0] mode);
    logic ok;
    case (mode)
      2'd0, 2'd1, 2'd2, 2'd3: ok = 1'b1;
      default:                ok = 1'b0;
    endcase
    return ok;
  endfunction

  // Address hold only lets a cycle through that opened before the hold.
  function automatic logic hold_allows(input logic hold_now, input logic opened_in_hold);
    return !(hold_now && opened_in_hold);
  endfunction

  function automatic logic line_cacheable(input logic ken, input logic creq);
    return ken & creq;
  endfunction

  function automatic logic line_writeback(input logic cach, input logic pt, input logic hint_wb);
    return cach & ~pt & hint_wb;
  endfunction
endpackage

// File: rtl/ceq_cycle_track.sv
module ceq_cycle_track
  import ceq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic [KIND_W-1:0] cyc_kind,
  input  logic              addr_hold,
  input  logic              strobe_any,
  output logic [KIND_W-1:0] kind_q,
  output logic              began_in_hold,
  output logic              window_open,
  output logic              sample_point
);
  logic active_q;
  logic closed_q;

  assign window_open  = active_q & ~closed_q;
  // The first strobe after the address strobe is the one sample point.
  assign sample_point = window_open & strobe_any & ~cyc_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q      <= 1'b0;
      closed_q      <= 1'b0;
      kind_q        <= CK_NONE;
      began_in_hold <= 1'b0;
    end else if (cyc_start) begin
      active_q      <= 1'b1;
      closed_q      <= 1'b0;
      kind_q        <= cyc_kind;
      began_in_hold <= addr_hold;
    end else if (sample_point) begin
      closed_q      <= 1'b1;
    end
  end
endmodule

// File: rtl/ceq_gate.sv
module ceq_gate
  import ceq_pkg::*;
(
  input  logic              sample_point,
  input  logic [KIND_W-1:0] kind_q,
  input  logic [MODE_W-1:0] op_mode,
  input  logic [PWR_W-1:0]  power_st,
  input  logic              backoff,
  input  logic              hold_ack,
  input  logic              hard_reset,
  input  logic              init_req,
  input  logic              probe_rdy,
  input  logic              addr_hold,
  input  logic              began_in_hold,
  output logic              bus_block,
  output logic              cap_fire
);
  logic [NUM_BLOCKERS-1:0] blk_vec;
  logic                    qualified;

  assign blk_vec   = {backoff, hold_ack, hard_reset, init_req, probe_rdy};
  assign bus_block = |blk_vec;

  always_comb begin
    qualified = kind_allows(kind_q)
              & mode_allows(op_mode)
              & power_allows(power_st)
              & hold_allows(addr_hold, began_in_hold)
              & ~bus_block;
    cap_fire  = sample_point & qualified;
  end
endmodule

// File: rtl/ceq_result.sv
module ceq_result
  import ceq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic cap_fire,
  input  logic cache_en,
  input  logic cache_req,
  input  logic pwt,
  input  logic wb_wt,
  output logic cacheable,
  output logic wb_policy
);
  logic cach_d;

  assign cach_d = line_cacheable(cache_en, cache_req);

  always_ff @(posedge clk) begin
    if (!rst_n || cyc_start) begin
      cacheable <= 1'b0;
      wb_policy <= 1'b0;
    end else if (cap_fire) begin
      cacheable <= cach_d;
      wb_policy <= line_writeback(cach_d, pwt, wb_wt);
    end
  end
endmodule

// File: rtl/cache_enable_qualifier.sv
module cache_enable_qualifier
  import ceq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic [KIND_W-1:0] cyc_kind,
  input  logic [MODE_W-1:0] op_mode,
  input  logic [PWR_W-1:0]  power_st,
  input  logic              backoff,
  input  logic              hold_ack,
  input  logic              hard_reset,
  input  logic              init_req,
  input  logic              probe_rdy,
  input  logic              addr_hold,
  input  logic              first_brdy,
  input  logic              next_addr,
  input  logic              cache_en,
  input  logic              cache_req,
  input  logic              pwt,
  input  logic              wb_wt,
  output logic              cap_stb,
  output logic              cacheable,
  output logic              wb_policy
);
  logic [KIND_W-1:0] kind_q;
  logic              began_in_hold;
  logic              window_open;
  logic              sample_point;
  logic              bus_block;
  logic              cap_fire;
  logic              strobe_any;

  assign strobe_any = first_brdy | next_addr;

  ceq_cycle_track u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .cyc_start     (cyc_start),
    .cyc_kind      (cyc_kind),
    .addr_hold     (addr_hold),
    .strobe_any    (strobe_any),
    .kind_q        (kind_q),
    .began_in_hold (began_in_hold),
    .window_open   (window_open),
    .sample_point  (sample_point)
  );

  ceq_gate u_gate (
    .sample_point  (sample_point),
    .kind_q        (kind_q),
    .op_mode       (op_mode),
    .power_st      (power_st),
    .backoff       (backoff),
    .hold_ack      (hold_ack),
    .hard_reset    (hard_reset),
    .init_req      (init_req),
    .probe_rdy     (probe_rdy),
    .addr_hold     (addr_hold),
    .began_in_hold (began_in_hold),
    .bus_block     (bus_block),
    .cap_fire      (cap_fire)
  );

  ceq_result u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .cap_fire  (cap_fire),
    .cache_en  (cache_en),
    .cache_req (cache_req),
    .pwt       (pwt),
    .wb_wt     (wb_wt),
    .cacheable (cacheable),
    .wb_policy (wb_policy)
  );

  assign cap_stb = cap_fire;
endmodule

// File: rtl/ceq_checker.sv
module ceq_checker
  import ceq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_start,
  input logic              cap_stb,
  input logic              cacheable,
  input logic              wb_policy,
  input logic [KIND_W-1:0] kind_q,
  input logic              began_in_hold,
  input logic              window_open,
  input logic              addr_hold,
  input logic [PWR_W-1:0]  power_st,
  input logic              bus_block,
  input logic              cache_en,
  input logic              cache_req
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!cacheable && !wb_policy && !cap_stb));

  p_single_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> !cap_stb);

  p_strobe_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |-> (window_open && !cyc_start));

  p_read_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |-> (kind_q == CK_MEM_RD));

  p_running_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |-> (power_st == PWR_RUN));

  p_bus_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |-> !bus_block);

  p_hold_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_stb && addr_hold) |-> !began_in_hold);

  p_latch_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> (cacheable == $past(cache_en && cache_req)));

  p_hold_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_start && !cap_stb) |=> $stable(cacheable));

  p_policy_implies_cache_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_policy |-> cacheable);

  p_clear_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> (!cacheable && !wb_policy));
endmodule

bind cache_enable_qualifier ceq_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cyc_start     (cyc_start),
  .cap_stb       (cap_stb),
  .cacheable     (cacheable),
  .wb_policy     (wb_policy),
  .kind_q        (kind_q),
  .began_in_hold (began_in_hold),
  .window_open   (window_open),
  .addr_hold     (addr_hold),
  .power_st      (power_st),
  .bus_block     (bus_block),
  .cache_en      (cache_en),
  .cache_req     (cache_req)
);

// File: tb/tb_cache_enable_qualifier.sv
`timescale 1ns/1ps
module tb_cache_enable_qualifier;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_start;
  logic [2:0] cyc_kind;
  logic [1:0] op_mode;
  logic [2:0] power_st;
  logic       backoff, hold_ack, hard_reset, init_req, probe_rdy, addr_hold;
  logic       first_brdy, next_addr, cache_en, cache_req, pwt, wb_wt;
  logic       cap_stb, cacheable, wb_policy;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  // Bench model of the bus cycle, built from the requirements.
  bit m_active, m_closed, m_hold_start, m_cach, m_wb;
  bit [2:0] m_kind;

  always #2.5 clk = ~clk;

  cache_enable_qualifier dut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_kind(cyc_kind),
    .op_mode(op_mode), .power_st(power_st), .backoff(backoff),
    .hold_ack(hold_ack), .hard_reset(hard_reset), .init_req(init_req),
    .probe_rdy(probe_rdy), .addr_hold(addr_hold), .first_brdy(first_brdy),
    .next_addr(next_addr), .cache_en(cache_en), .cache_req(cache_req),
    .pwt(pwt), .wb_wt(wb_wt), .cap_stb(cap_stb), .cacheable(cacheable),
    .wb_policy(wb_policy)
  );

  function automatic bit sample_clock();
    return rst_n && m_active && !m_closed && !cyc_start && (first_brdy || next_addr);
  endfunction

  function automatic bit expect_cap();
    bit ok;
    ok = (m_kind == 3'd0) && (power_st == 3'd0)
      && !(backoff || hold_ack || hard_reset || init_req || probe_rdy)
      && !(addr_hold && m_hold_start);
    return sample_clock() && ok;
  endfunction

  task automatic chk(input string tag, input string what, input bit act, input bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    cyc_start = 0; cyc_kind = 3'd0; op_mode = 2'd0; power_st = 3'd0;
    backoff = 0; hold_ack = 0; hard_reset = 0; init_req = 0; probe_rdy = 0;
    addr_hold = 0; first_brdy = 0; next_addr = 0;
    cache_en = 0; cache_req = 0; pwt = 0; wb_wt = 0;
  endtask

  // Inputs are set at a falling edge; check, take the rising edge, update the model.
  task automatic tick(input string tag);
    bit ec;
    #1;
    ec = expect_cap();
    chk(tag, "cap_stb", cap_stb, ec);
    chk(tag, "cacheable", cacheable, m_cach);
    chk(tag, "wb_policy", wb_policy, m_wb);
    @(posedge clk);
    if (!rst_n) begin
      m_active = 0; m_closed = 0; m_cach = 0; m_wb = 0; m_kind = 3'd7; m_hold_start = 0;
    end else if (cyc_start) begin
      m_active = 1; m_closed = 0; m_kind = cyc_kind; m_hold_start = addr_hold;
      m_cach = 0; m_wb = 0;
    end else if (sample_clock()) begin
      m_closed = 1;
      if (ec) begin
        m_cach = cache_en && cache_req;
        m_wb   = m_cach && !pwt && wb_wt;
      end
    end
    @(negedge clk);
  endtask

  task automatic open_cycle(input string tag, input bit [2:0] kind, input bit hold);
    cyc_start = 1; cyc_kind = kind; addr_hold = hold;
    tick(tag);
    cyc_start = 0; cyc_kind = 3'd0;
  endtask

  task automatic pulse(input string tag, input bit brdy, input bit na);
    first_brdy = brdy; next_addr = na;
    tick(tag);
    first_brdy = 0; next_addr = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    idle();
    rst_n = 0;
    m_kind = 3'd7;
    @(negedge clk);
    // R1: reset state
    repeat (3) tick("R1");
    rst_n = 1;
    tick("R1");

    // R2: next-address first, later burst-ready ignored
    cache_en = 1; cache_req = 1; wb_wt = 1;
    open_cycle("R2", 3'd0, 0);
    tick("R2");
    pulse("R2", 0, 1);
    pulse("R2", 1, 0);
    tick("R2");
    // R2: burst-ready alone
    open_cycle("R2", 3'd0, 0);
    pulse("R2", 1, 0);
    tick("R2");

    // R3: every non-read kind
    for (int k = 1; k < 7; k++) begin
      open_cycle("R3", 3'(k), 0);
      pulse("R3", 1, 0);
      tick("R3");
    end

    // R4: stopping power states, then all modes
    for (int p = 1; p < 5; p++) begin
      open_cycle("R4", 3'd0, 0);
      power_st = 3'(p);
      pulse("R4", 1, 0);
      power_st = 3'd0;
      pulse("R4", 1, 0);
    end
    for (int m = 0; m < 4; m++) begin
      op_mode = 2'(m);
      open_cycle("R4", 3'd0, 0);
      pulse("R4", 0, 1);
      tick("R4");
    end
    op_mode = 2'd0;

    // R5: each blocker on the sample clock closes the window uncached
    for (int b = 0; b < 5; b++) begin
      open_cycle("R5", 3'd0, 0);
      {backoff, hold_ack, hard_reset, init_req, probe_rdy} = 5'(1 << b);
      pulse("R5", 1, 0);
      {backoff, hold_ack, hard_reset, init_req, probe_rdy} = 5'd0;
      pulse("R5", 1, 0);
      tick("R5");
    end

    // R6: hold after start captures; start under hold does not
    open_cycle("R6", 3'd0, 0);
    addr_hold = 1;
    pulse("R6", 1, 0);
    tick("R6");
    open_cycle("R6", 3'd0, 1);
    pulse("R6", 1, 0);
    addr_hold = 0;
    tick("R6");

    // R7 / R8: value combinations
    for (int v = 0; v < 16; v++) begin
      open_cycle("R7", 3'd0, 0);
      {cache_en, cache_req, pwt, wb_wt} = 4'(v);
      pulse("R8", 1, 0);
      {cache_en, cache_req, pwt, wb_wt} = 4'd0;
      tick("R7");
    end

    // R9: strobe in the start clock is ignored, start clears result
    cache_en = 1; cache_req = 1; wb_wt = 1;
    open_cycle("R9", 3'd0, 0);
    pulse("R9", 1, 0);
    cyc_start = 1; first_brdy = 1;
    tick("R9");
    cyc_start = 0; first_brdy = 0;
    tick("R9");
    pulse("R9", 0, 1);
    tick("R9");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      cyc_start  = ($urandom % 6) == 0;
      cyc_kind   = (($urandom % 3) == 0) ? 3'($urandom % 7) : 3'd0;
      op_mode    = 2'($urandom % 4);
      power_st   = (($urandom % 8) == 0) ? 3'(1 + $urandom % 4) : 3'd0;
      backoff    = ($urandom % 12) == 0;
      hold_ack   = ($urandom % 12) == 0;
      hard_reset = ($urandom % 12) == 0;
      init_req   = ($urandom % 12) == 0;
      probe_rdy  = ($urandom % 12) == 0;
      addr_hold  = ($urandom % 4) == 0;
      first_brdy = ($urandom % 3) == 0;
      next_addr  = ($urandom % 4) == 0;
      cache_en   = ($urandom % 2) == 0;
      cache_req  = ($urandom % 4) != 0;
      pwt        = ($urandom % 2) == 0;
      wb_wt      = ($urandom % 2) == 0;
      tick("R7");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule